// File: doc/BRIEF.md
# Byte-wide counter register interface

This block is the host side of a 24-bit event counter. A processor reaches it through an 8-bit data bus with four active-low strobes: chip select, read, write, and a control/data select. Through this bus the processor programs four mode registers and fills a 3-byte preset value. It issues one-shot commands to the counter core, and reads back a 3-byte output latch and a status byte. The counter arithmetic itself sits in a separate core. This block hands that core the preset value, the mode registers and single-cycle command pulses. The core returns its live count and its status flags.

The strobes are synchronous enables sampled on the system clock. An access FSM accepts exactly one access for each assertion of a strobe. It has two states. `ACC_IDLE` moves to `ACC_HOLD` when an access is accepted. `ACC_HOLD` moves back to `ACC_IDLE` when chip select rises or both read and write are high.

A second FSM is the byte pointer. It is shared by preset writes and latch reads and has three states: `PTR_B0`, `PTR_B1` and `PTR_B2`. On each data access it steps `PTR_B0`→`PTR_B1`→`PTR_B2`→`PTR_B0`. A pointer clear, whether on its own or as part of a master reset, returns it to `PTR_B0`.

All control writes share one address. The two top data bits choose which control register receives the byte. The bus driver is modelled as a data output plus a separate output enable.

Top module: `cnt_host_if`

## Requirements
- R1: An access is accepted only in the first clock in which chip select is low and exactly one of read or write is low. Further cycles with the strobe held do nothing. A cycle with read and write both low performs no access.
- R2: While chip select is high, no register, preset, latch, pointer or command output changes, whatever the other strobes do.
- R3: A control write (cd=1) is routed by din[7:6]:
  - 00 is the master command register.
  - 01 loads in_ctl from din[5:0].
  - 10 loads out_ctl from din[5:0].
  - 11 loads quad_ctl from din[1:0].
  - The new value is on the port from the clock after the accepting edge.
- R4: A data write (cd=0) stores din in the preset byte the pointer selects: byte 0 is preset[7:0], byte 1 is preset[15:8] and byte 2 is preset[23:16]. The pointer then steps, and after byte 2 it returns to byte 0.
- R5: A data read (cd=0) captures the latch byte the pointer selects, with the same byte order as R4. It steps the same pointer that preset writes use.
- R6: Master command bit 0 returns the pointer to byte 0. Bit 1 copies cnt_val into the output latch. Both act in the same write when both are set.
- R7: Master command bits 2, 3 and 4 each produce a pulse one clock wide, in the clock after the accepting edge: bit 2 on cmd_cnt_clr, bit 3 on cmd_load and bit 4 on cmd_cmp_clr. Every bit set in one write pulses, and no zero write is needed afterwards. No pulse occurs without a master write.
- R8: Master command bit 5 does all of the following:
  - clears in_ctl, out_ctl and quad_ctl;
  - sets preset to all ones;
  - clears the output latch, even when bit 1 is also set;
  - returns the pointer to byte 0;
  - pulses cmd_mreset for one clock.
- R9: A control read (cd=1) captures the status byte {3'b000, st_flags[4:0]}. Its bits are 0 borrow toggle, 1 carry toggle, 2 compare toggle, 3 sign and 4 up/down.
- R10: dout_oe is high exactly while cs_n and rd_n are both low. dout holds the byte captured by the most recent read, and changes only on the clock edge that accepts a read.
- R11: After reset, the following hold:
  - preset is all ones;
  - mode registers, latch and dout are zero;
  - the pointer is at byte 0;
  - no command pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd | input | 1 | 1 selects control/status, 0 selects preset/latch data |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data captured at the last accepted read |
| dout_oe | output | 1 | Drive enable for the host data bus |
| cnt_val | input | 24 | Live count value from the counter core |
| st_flags | input | 5 | Core status flags: borrow toggle, carry toggle, compare toggle, sign, up/down |
| preset | output | 24 | Preset value handed to the core |
| in_ctl | output | 6 | Input mode register |
| out_ctl | output | 6 | Output and count mode register |
| quad_ctl | output | 2 | Quadrature mode register |
| cmd_load | output | 1 | One-clock pulse: load preset into the counter |
| cmd_cnt_clr | output | 1 | One-clock pulse: clear the counter |
| cmd_cmp_clr | output | 1 | One-clock pulse: clear the compare toggle |
| cmd_mreset | output | 1 | One-clock pulse: master reset of the core |

## Verification
The assertions watch five rules on every clock:
- chip select high freezes all programmed state and command outputs;
- command pulses last one clock and follow a control write;
- a master reset pulse coincides with cleared mode registers and an all-ones preset;
- the preset changes only after a write strobe;
- dout moves only after a read strobe.

Other rules depend on a sequence of accesses, so only the bench's scenarios can show them:
- the byte order through the shared pointer and its wrap;
- pointer clear combined with a latch copy;
- master reset clearing a latch that was just copied;
- a held or doubled strobe counting as one access or none.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;
    // number of bytes in the preset and in the output latch
    localparam int NBYTES = 3;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_HOLD = 1'b1
    } acc_state_t;

    typedef enum logic [1:0] {
        PTR_B0 = 2'd0,
        PTR_B1 = 2'd1,
        PTR_B2 = 2'd2
    } ptr_state_t;

    typedef enum logic [1:0] {
        SEL_MASTER = 2'd0,
        SEL_INPUT  = 2'd1,
        SEL_OUTPUT = 2'd2,
        SEL_QUAD   = 2'd3
    } ctl_sel_t;

    // master command bit positions
    localparam int MC_PTR_CLR = 0;
    localparam int MC_LATCH   = 1;
    localparam int MC_CNT_CLR = 2;
    localparam int MC_LOAD    = 3;
    localparam int MC_CMP_CLR = 4;
    localparam int MC_MRESET  = 5;
endpackage

// File: rtl/chif_access_fsm.sv
module chif_access_fsm
    import cnt_host_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic acc_wr,
    output logic acc_rd
);
    acc_state_t state_q, state_d;
    logic       start_wr, start_rd, released;

    assign start_wr = !cs_n && !wr_n && rd_n;
    assign start_rd = !cs_n && !rd_n && wr_n;
    assign released = cs_n || (rd_n && wr_n);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (start_wr || start_rd) state_d = ACC_HOLD;
            ACC_HOLD: if (released)             state_d = ACC_IDLE;
            default:                            state_d = ACC_IDLE;
        endcase
    end

    // outputs: one access strobe per assertion
    always_comb begin
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        unique case (state_q)
            ACC_IDLE: begin
                acc_wr = start_wr;
                acc_rd = start_rd;
            end
            ACC_HOLD: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/chif_ptr_fsm.sv
module chif_ptr_fsm
    import cnt_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ptr_clr,
    input  logic       ptr_step,
    output ptr_state_t ptr_sel
);
    ptr_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_B0;
        else        state_q <= state_d;
    end

    // clear wins over step
    always_comb begin
        state_d = state_q;
        if (ptr_clr) begin
            state_d = PTR_B0;
        end else if (ptr_step) begin
            unique case (state_q)
                PTR_B0:  state_d = PTR_B1;
                PTR_B1:  state_d = PTR_B2;
                PTR_B2:  state_d = PTR_B0;
                default: state_d = PTR_B0;
            endcase
        end
    end

    always_comb ptr_sel = state_q;
endmodule

// File: rtl/chif_regs.sv
module chif_regs
    import cnt_host_pkg::*;
#(
    parameter int DW     = 8,
    parameter int MODE_W = 6,
    parameter int QUAD_W = 2,
    localparam int CW    = NBYTES * DW,
    localparam int STW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic              cd,
    input  logic [DW-1:0]     din,
    input  logic [CW-1:0]     cnt_val,
    input  logic [STW-1:0]    st_flags,
    input  ptr_state_t        ptr_sel,
    output logic              ptr_clr,
    output logic              ptr_step,
    output logic [DW-1:0]     dout,
    output logic [CW-1:0]     preset,
    output logic [MODE_W-1:0] in_ctl,
    output logic [MODE_W-1:0] out_ctl,
    output logic [QUAD_W-1:0] quad_ctl,
    output logic              cmd_load,
    output logic              cmd_cnt_clr,
    output logic              cmd_cmp_clr,
    output logic              cmd_mreset
);
    ctl_sel_t      sel;
    logic          wr_ctl, wr_mcr, do_mreset;
    logic [CW-1:0] latch_q;
    logic [DW-1:0] latch_byte;

    assign sel       = ctl_sel_t'(din[DW-1:DW-2]);
    assign wr_ctl    = acc_wr && cd;
    assign wr_mcr    = wr_ctl && (sel == SEL_MASTER);
    assign do_mreset = wr_mcr && din[MC_MRESET];
    assign ptr_clr   = wr_mcr && (din[MC_PTR_CLR] || din[MC_MRESET]);
    assign ptr_step  = (acc_wr || acc_rd) && !cd;

    // mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ctl   <= '0;
            out_ctl  <= '0;
            quad_ctl <= '0;
        end else if (do_mreset) begin
            in_ctl   <= '0;
            out_ctl  <= '0;
            quad_ctl <= '0;
        end else if (wr_ctl) begin
            unique case (sel)
                SEL_INPUT:  in_ctl   <= din[MODE_W-1:0];
                SEL_OUTPUT: out_ctl  <= din[MODE_W-1:0];
                SEL_QUAD:   quad_ctl <= din[QUAD_W-1:0];
                SEL_MASTER: ;
                default: ;
            endcase
        end
    end

    // preset bytes, addressed by the shared pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            preset <= '1;
        end else if (do_mreset) begin
            preset <= '1;
        end else if (acc_wr && !cd) begin
            unique case (ptr_sel)
                PTR_B0:  preset[DW-1:0]      <= din;
                PTR_B1:  preset[2*DW-1:DW]   <= din;
                PTR_B2:  preset[3*DW-1:2*DW] <= din;
                default: ;
            endcase
        end
    end

    // output latch: master reset wins over a copy in the same write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             latch_q <= '0;
        else if (do_mreset)                     latch_q <= '0;
        else if (wr_mcr && din[MC_LATCH])       latch_q <= cnt_val;
    end

    // command pulses, one clock after the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_load    <= 1'b0;
            cmd_cnt_clr <= 1'b0;
            cmd_cmp_clr <= 1'b0;
            cmd_mreset  <= 1'b0;
        end else begin
            cmd_load    <= wr_mcr && din[MC_LOAD];
            cmd_cnt_clr <= wr_mcr && din[MC_CNT_CLR];
            cmd_cmp_clr <= wr_mcr && din[MC_CMP_CLR];
            cmd_mreset  <= do_mreset;
        end
    end

    always_comb begin
        unique case (ptr_sel)
            PTR_B0:  latch_byte = latch_q[DW-1:0];
            PTR_B1:  latch_byte = latch_q[2*DW-1:DW];
            PTR_B2:  latch_byte = latch_q[3*DW-1:2*DW];
            default: latch_byte = latch_q[DW-1:0];
        endcase
    end

    // read data captured at the accepting edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dout <= '0;
        else if (acc_rd) dout <= cd ? {{(DW-STW){1'b0}}, st_flags} : latch_byte;
    end
endmodule

// File: rtl/cnt_host_if.sv
module cnt_host_if
    import cnt_host_pkg::*;
#(
    parameter int DW     = 8,
    parameter int MODE_W = 6,
    parameter int QUAD_W = 2,
    localparam int CW    = NBYTES * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cd,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    input  logic [CW-1:0]     cnt_val,
    input  logic [4:0]        st_flags,
    output logic [CW-1:0]     preset,
    output logic [MODE_W-1:0] in_ctl,
    output logic [MODE_W-1:0] out_ctl,
    output logic [QUAD_W-1:0] quad_ctl,
    output logic              cmd_load,
    output logic              cmd_cnt_clr,
    output logic              cmd_cmp_clr,
    output logic              cmd_mreset
);
    logic       acc_wr, acc_rd, ptr_clr, ptr_step;
    ptr_state_t ptr_sel;

    chif_access_fsm u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .acc_wr (acc_wr),
        .acc_rd (acc_rd)
    );

    chif_ptr_fsm u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_clr  (ptr_clr),
        .ptr_step (ptr_step),
        .ptr_sel  (ptr_sel)
    );

    chif_regs #(.DW(DW), .MODE_W(MODE_W), .QUAD_W(QUAD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .cd          (cd),
        .din         (din),
        .cnt_val     (cnt_val),
        .st_flags    (st_flags),
        .ptr_sel     (ptr_sel),
        .ptr_clr     (ptr_clr),
        .ptr_step    (ptr_step),
        .dout        (dout),
        .preset      (preset),
        .in_ctl      (in_ctl),
        .out_ctl     (out_ctl),
        .quad_ctl    (quad_ctl),
        .cmd_load    (cmd_load),
        .cmd_cnt_clr (cmd_cnt_clr),
        .cmd_cmp_clr (cmd_cmp_clr),
        .cmd_mreset  (cmd_mreset)
    );

    // bus drive enable follows the strobes directly
    assign dout_oe = !cs_n && !rd_n;
endmodule

// File: rtl/chif_checker.sv
module chif_checker #(
    parameter int DW     = 8,
    parameter int MODE_W = 6,
    parameter int QUAD_W = 2,
    parameter int CW     = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              cd,
    input logic [DW-1:0]     dout,
    input logic [CW-1:0]     preset,
    input logic [MODE_W-1:0] in_ctl,
    input logic [MODE_W-1:0] out_ctl,
    input logic [QUAD_W-1:0] quad_ctl,
    input logic              cmd_load,
    input logic              cmd_cnt_clr,
    input logic              cmd_cmp_clr,
    input logic              cmd_mreset
);
    logic any_cmd;
    assign any_cmd = cmd_load || cmd_cnt_clr || cmd_cmp_clr || cmd_mreset;

    AST_CS_FREEZES_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(preset) && $stable(in_ctl) && $stable(out_ctl) && $stable(quad_ctl))); // R2
    AST_CS_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !any_cmd); // R2
    AST_LOAD_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_load |=> !cmd_load); // R7
    AST_CNT_CLR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt_clr |=> !cmd_cnt_clr); // R7
    AST_CMD_AFTER_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        any_cmd |-> $past(!cs_n && !wr_n && cd)); // R7
    AST_MRESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mreset |-> (preset == '1 && in_ctl == '0 && out_ctl == '0 && quad_ctl == '0)); // R8
    AST_PRESET_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preset) |-> $past(!cs_n && !wr_n)); // R4
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n |=> $stable(dout)); // R10
endmodule

bind cnt_host_if chif_checker #(.DW(DW), .MODE_W(MODE_W), .QUAD_W(QUAD_W), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .cd          (cd),
    .dout        (dout),
    .preset      (preset),
    .in_ctl      (in_ctl),
    .out_ctl     (out_ctl),
    .quad_ctl    (quad_ctl),
    .cmd_load    (cmd_load),
    .cmd_cnt_clr (cmd_cnt_clr),
    .cmd_cmp_clr (cmd_cmp_clr),
    .cmd_mreset  (cmd_mreset)
);

// File: tb/cnt_host_if_tb.sv
`timescale 1ns/1ps
module cnt_host_if_tb;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd = 1'b0;
    logic [7:0]  din = '0;
    logic [23:0] cnt_val = '0;
    logic [4:0]  st_flags = '0;
    logic [7:0]  dout;
    logic        dout_oe;
    logic [23:0] preset;
    logic [5:0]  in_ctl, out_ctl;
    logic [1:0]  quad_ctl;
    logic        cmd_load, cmd_cnt_clr, cmd_cmp_clr, cmd_mreset;

    cnt_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .cd(cd),
        .din(din), .dout(dout), .dout_oe(dout_oe), .cnt_val(cnt_val), .st_flags(st_flags),
        .preset(preset), .in_ctl(in_ctl), .out_ctl(out_ctl), .quad_ctl(quad_ctl),
        .cmd_load(cmd_load), .cmd_cnt_clr(cmd_cnt_clr), .cmd_cmp_clr(cmd_cmp_clr),
        .cmd_mreset(cmd_mreset)
    );

    always #5 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_idle = 1'b1;
    int          m_ptr = 0;
    logic [23:0] m_preset = 24'hFFFFFF, m_latch = '0;
    logic [5:0]  m_in = '0, m_out = '0;
    logic [1:0]  m_quad = '0;
    logic [7:0]  m_dout = '0;
    bit          m_load, m_cclr, m_cmpclr, m_mrst;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle = 1; m_ptr = 0; m_preset = 24'hFFFFFF; m_latch = 0;
            m_in = 0; m_out = 0; m_quad = 0; m_dout = 0;
            m_load = 0; m_cclr = 0; m_cmpclr = 0; m_mrst = 0;
        end else begin
            m_load = 0; m_cclr = 0; m_cmpclr = 0; m_mrst = 0;
            if (m_idle) begin
                if (!cs_n && (rd_n != wr_n)) begin
                    m_idle = 0;
                    if (!wr_n) begin
                        if (cd) begin
                            case (din[7:6])
                                2'd0: begin
                                    if (din[0]) m_ptr = 0;
                                    if (din[1]) m_latch = cnt_val;
                                    m_cclr = din[2]; m_load = din[3]; m_cmpclr = din[4];
                                    if (din[5]) begin
                                        m_mrst = 1; m_in = 0; m_out = 0; m_quad = 0;
                                        m_preset = 24'hFFFFFF; m_latch = 0; m_ptr = 0;
                                    end
                                end
                                2'd1: m_in = din[5:0];
                                2'd2: m_out = din[5:0];
                                default: m_quad = din[1:0];
                            endcase
                        end else begin
                            m_preset[m_ptr*8 +: 8] = din;
                            m_ptr = (m_ptr + 1) % 3;
                        end
                    end else begin
                        if (cd) m_dout = {3'b000, st_flags};
                        else begin
                            m_dout = m_latch[m_ptr*8 +: 8];
                            m_ptr = (m_ptr + 1) % 3;
                        end
                    end
                end
            end else if (cs_n || (rd_n && wr_n)) begin
                m_idle = 1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R5 dout", dout, m_dout);
            check("R10 dout_oe", dout_oe, !cs_n && !rd_n);
            check("R4 preset", preset, m_preset);
            check("R3 in_ctl", in_ctl, m_in);
            check("R3 out_ctl", out_ctl, m_out);
            check("R3 quad_ctl", quad_ctl, m_quad);
            check("R7 cmd_load", cmd_load, m_load);
            check("R7 cmd_cnt_clr", cmd_cnt_clr, m_cclr);
            check("R7 cmd_cmp_clr", cmd_cmp_clr, m_cmpclr);
            check("R8 cmd_mreset", cmd_mreset, m_mrst);
        end
    end

    // ---------------- stimulus ----------------
    logic [7:0] seen_byte;
    logic [3:0] seen_pulse; // {mreset, cmp_clr, load, cnt_clr}
    logic       seen_oe;

    task automatic bus_op(input bit is_wr, input bit c, input logic [7:0] d, input int hold);
        @(negedge clk); #1;
        cs_n = 0; cd = c; din = d;
        if (is_wr) wr_n = 0; else rd_n = 0;
        @(negedge clk);
        seen_byte  = dout;
        seen_oe    = dout_oe;
        seen_pulse = {cmd_mreset, cmd_cmp_clr, cmd_load, cmd_cnt_clr};
        repeat (hold) @(negedge clk);
        #1; cs_n = 1; wr_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    task automatic wr(input bit c, input logic [7:0] d); bus_op(1, c, d, 1); endtask
    task automatic rd(input bit c);                      bus_op(0, c, 8'h00, 1); endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check("R11 preset", preset, 24'hFFFFFF);
        check("R11 modes", {in_ctl, out_ctl, quad_ctl}, 0);
        check("R11 dout", dout, 0);

        // R3 control register routing
        wr(1, 8'h6A); check("R3 in_ctl", in_ctl, 6'h2A);
        wr(1, 8'h95); check("R3 out_ctl", out_ctl, 6'h15);
        wr(1, 8'hC2); check("R3 quad_ctl", quad_ctl, 2'b10);

        // R4 preset bytes in order, then wrap
        wr(1, 8'h01);
        wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33);
        check("R4 preset fill", preset, 24'h332211);
        wr(0, 8'h44);
        check("R4 preset wrap", preset, 24'h332244);

        // R6 pointer clear and latch copy in one write
        cnt_val = 24'hABCDEF;
        wr(1, 8'h03);
        cnt_val = 24'h000000;
        rd(0); check("R6 latch byte0", seen_byte, 8'hEF);
        rd(0); check("R5 latch byte1", seen_byte, 8'hCD);
        rd(0); check("R5 latch byte2", seen_byte, 8'hAB);
        rd(0); check("R5 read wrap", seen_byte, 8'hEF);
        // shared pointer: now at byte 1
        wr(0, 8'h55); check("R5 shared pointer", preset, 24'h335544);

        // R7 combined and single command pulses
        wr(1, 8'h1C); check("R7 combined pulses", seen_pulse, 4'b0111);
        check("R7 pulses end", {cmd_mreset, cmd_cmp_clr, cmd_load, cmd_cnt_clr}, 0);
        wr(1, 8'h08); check("R7 load pulse", seen_pulse, 4'b0010);
        wr(1, 8'h00); check("R7 zero write", seen_pulse, 4'b0000);

        // R9 status read, R10 output enable
        st_flags = 5'b10110;
        rd(1);
        check("R9 status", seen_byte, 8'h16);
        check("R10 oe during read", seen_oe, 1'b1);
        check("R10 oe released", dout_oe, 1'b0);
        check("R10 dout held", dout, 8'h16);

        // R2 chip select high blocks access
        @(negedge clk); #1; cs_n = 1; wr_n = 0; cd = 0; din = 8'h99;
        repeat (2) @(negedge clk);
        #1; wr_n = 1; rd_n = 0;
        @(negedge clk);
        check("R2 oe blocked", dout_oe, 1'b0);
        #1; rd_n = 1;
        @(negedge clk);
        check("R2 preset kept", preset, 24'h335544);
        check("R2 dout kept", dout, 8'h16);

        // R1 both strobes low: no access
        @(negedge clk); #1; cs_n = 0; wr_n = 0; rd_n = 0; cd = 0; din = 8'h99;
        repeat (2) @(negedge clk);
        #1; cs_n = 1; wr_n = 1; rd_n = 1;
        @(negedge clk);
        check("R1 double strobe", preset, 24'h335544);
        // R1 held strobe counts once
        wr(1, 8'h01);
        bus_op(1, 0, 8'h77, 4);
        check("R1 held write", preset, 24'h335577);
        wr(0, 8'h88);
        check("R1 pointer stepped once", preset, 24'h338877);

        // R8 master reset combined with latch copy
        cnt_val = 24'h123456;
        wr(1, 8'h22);
        check("R8 mreset pulse", seen_pulse, 4'b1000);
        check("R8 modes cleared", {in_ctl, out_ctl, quad_ctl}, 0);
        check("R8 preset ones", preset, 24'hFFFFFF);
        rd(0); check("R8 latch cleared", seen_byte, 8'h00);
        wr(0, 8'hAA); check("R8 pointer at byte0", preset, 24'hFFAAFF);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule